// File: doc/BRIEF.md
# Horizontal Line Period Slew Controller

This block produces the horizontal line period that a deflection PLL runs at. The period is a count of cycles of a 48 MHz reference clock. It spans 343 to 1920 cycles, which covers line rates from about 140 kHz down to 25 kHz. The period never jumps to a new value. It walks toward a goal one count at a time, at a pace set by software, and it always stays inside a window set by two limit registers.

After reset the period sits at 800 cycles, which is 60 kHz, and the drive-enable output is low. Stepping begins on the first cycle that the clock-enable input is high. The goal for start-up is taken from the free-running period register at that moment, clamped into the limit window. The block then walks to that goal without interruption. Once the goal is reached, a start-up-done flag and drive enable rise. From then on, any new free-running value, for example after a mode change, becomes the new goal.

The two limit registers and the step-gap register accept only the first write after reset. A later write to any of them changes nothing and sets a sticky error flag. The control register and the free-running register can be rewritten at any time. Setting bit 0 of the control register makes the period load its goal directly instead of stepping toward it.

Top module: `hperiod_slew`

## Requirements
- R1: After reset: period = 800, start-up-done = 0, drive enable = 0, error flag = 0. Register defaults: control 0, free-running 800, lower limit 343, upper limit 1920, step gap DEF_GAP.
- R2: Before `ce` has first been high, the period stays at 800. In any cycle with `ce` low, the period and the step timer hold their values.
- R3: With control bit 0 clear, the period moves by exactly one count toward the goal, with consecutive steps exactly gap+1 enabled cycles apart. It stops on the goal.
- R4: The start-up goal is captured on the first `ce`-high cycle. Writes to the free-running register before start-up completes do not change that goal.
- R5: `startup_done` rises one cycle after the period first equals the start-up goal and then stays high. `drive_en` rises together with it and stays high.
- R6: After start-up completes, every change of the clamped free-running value becomes the new goal, and the period slews to it.
- R7: The goal is the free-running value clamped into [lower limit, upper limit]. When the lower limit exceeds the upper limit, the upper limit wins. Values written to the free-running and limit registers are first saturated into [343, 1920].
- R8: The limit and step-gap registers take only their first write after reset. Any later write to them is ignored and sets `cfg_err`, which stays set until reset.
- R9: With control bit 0 set, the period takes the goal on the next enabled cycle after the goal changes, with no stepping.
- R10: Register map by `wr_addr`: 0 = control (bit 0 = direct load), 1 = free-running period, 2 = lower period limit, 3 = upper period limit, 4 = step gap (low 8 bits). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the period logic |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| period | output | 11 | Current line period in reference cycles |
| startup_done | output | 1 | Start-up slew finished (sticky) |
| drive_en | output | 1 | Line drive may be enabled |
| cfg_err | output | 1 | Sticky flag: repeated write to a write-once register |

## Verification
Free-running values are tried below, inside and above the limit window, and at exactly the window edges. This separates correct clamping from simply passing the value through. Every walk is checked for unit steps and a fixed gap+1 spacing, so a wrong step size or pace shows up as well as a wrong end point. A rewrite during start-up, a second write to each write-once register, a write to an unmapped address, a `ce` pause in mid-walk, and direct-load mode each check that state which must stay put does not move. A second reset with out-of-range writes checks saturation of the written values.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int A_CTRL = 0;
  localparam int A_FREE = 1;
  localparam int A_LO   = 2;
  localparam int A_HI   = 3;
  localparam int A_GAP  = 4;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/hps_regs.sv
module hps_regs #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int PW      = 11,
  parameter int GW      = 8,
  parameter int ABS_MIN = 343,
  parameter int ABS_MAX = 1920,
  parameter int START_P = 800,
  parameter int DEF_GAP = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          direct,
  output logic [PW-1:0] free_p,
  output logic [PW-1:0] lim_lo,
  output logic [PW-1:0] lim_hi,
  output logic [GW-1:0] gap,
  output logic          err
);
  import hps_pkg::*;

  localparam int NONCE = 3;  // lower limit, upper limit, gap

  function automatic logic [PW-1:0] sat(input logic [DW-1:0] v);
    if (32'(v) < ABS_MIN)      sat = PW'(ABS_MIN);
    else if (32'(v) > ABS_MAX) sat = PW'(ABS_MAX);
    else                       sat = v[PW-1:0];
  endfunction

  logic [NONCE-1:0] hit_once;
  logic [NONCE-1:0] used;
  logic             hit_ctrl, hit_free;

  assign hit_ctrl    = wr_en && (wr_addr == AW'(A_CTRL));
  assign hit_free    = wr_en && (wr_addr == AW'(A_FREE));
  assign hit_once[0] = wr_en && (wr_addr == AW'(A_LO));
  assign hit_once[1] = wr_en && (wr_addr == AW'(A_HI));
  assign hit_once[2] = wr_en && (wr_addr == AW'(A_GAP));

  generate
    for (genvar i = 0; i < NONCE; i++) begin : g_once
      always_ff @(posedge clk) begin
        if (rst)              used[i] <= 1'b0;
        else if (hit_once[i]) used[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      direct <= 1'b0;
      free_p <= PW'(START_P);
      lim_lo <= PW'(ABS_MIN);
      lim_hi <= PW'(ABS_MAX);
      gap    <= GW'(DEF_GAP);
      err    <= 1'b0;
    end else begin
      if (hit_ctrl) direct <= wr_data[0];
      if (hit_free) free_p <= sat(wr_data);
      if (hit_once[0] && !used[0]) lim_lo <= sat(wr_data);
      if (hit_once[1] && !used[1]) lim_hi <= sat(wr_data);
      if (hit_once[2] && !used[2]) gap    <= wr_data[GW-1:0];
      if (|(hit_once & used))      err    <= 1'b1;
    end
  end
endmodule

// File: rtl/hps_clamp.sv
module hps_clamp #(
  parameter int PW = 11
) (
  input  logic [PW-1:0] free_p,
  input  logic [PW-1:0] lim_lo,
  input  logic [PW-1:0] lim_hi,
  output logic [PW-1:0] tgt
);
  logic [PW-1:0] above_lo;

  always_comb begin
    above_lo = (free_p < lim_lo) ? lim_lo : free_p;
    tgt      = (above_lo > lim_hi) ? lim_hi : above_lo;
  end
endmodule

// File: rtl/hps_stepper.sv
module hps_stepper #(
  parameter int PW      = 11,
  parameter int GW      = 8,
  parameter int START_P = 800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          run,
  input  logic          direct,
  input  logic [PW-1:0] goal,
  input  logic [GW-1:0] gap,
  output logic [PW-1:0] period
);
  logic [GW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= PW'(START_P);
      tmr    <= '0;
    end else if (ce && run) begin
      if (direct) begin
        period <= goal;
        tmr    <= '0;
      end else if (period == goal) begin
        tmr <= '0;
      end else if (tmr >= gap) begin
        tmr    <= '0;
        period <= (period < goal) ? period + 1'b1 : period - 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hperiod_slew.sv
module hperiod_slew #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int PW      = 11,
  parameter int GW      = 8,
  parameter int ABS_MIN = 343,
  parameter int ABS_MAX = 1920,
  parameter int START_P = 800,
  parameter int DEF_GAP = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [PW-1:0] period,
  output logic          startup_done,
  output logic          drive_en,
  output logic          cfg_err
);
  import hps_pkg::*;

  logic          direct;
  logic [PW-1:0] free_p, lim_lo, lim_hi, tgt, goal;
  logic [GW-1:0] gap;
  phase_t        phase;
  logic          started;

  hps_regs #(
    .DW(DW), .AW(AW), .PW(PW), .GW(GW), .ABS_MIN(ABS_MIN),
    .ABS_MAX(ABS_MAX), .START_P(START_P), .DEF_GAP(DEF_GAP)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .direct(direct), .free_p(free_p), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .gap(gap), .err(cfg_err)
  );

  hps_clamp #(.PW(PW)) u_clamp (
    .free_p(free_p), .lim_lo(lim_lo), .lim_hi(lim_hi), .tgt(tgt)
  );

  assign started = (phase != PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_WAIT;
      goal         <= PW'(START_P);
      startup_done <= 1'b0;
      drive_en     <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT: begin
          goal <= tgt;
          if (ce) phase <= PH_START;
        end
        PH_START: begin
          if (period == goal) begin
            phase        <= PH_RUN;
            startup_done <= 1'b1;
            drive_en     <= 1'b1;
          end
        end
        default: goal <= tgt;
      endcase
    end
  end

  hps_stepper #(.PW(PW), .GW(GW), .START_P(START_P)) u_step (
    .clk(clk), .rst(rst), .ce(ce), .run(started), .direct(direct),
    .goal(goal), .gap(gap), .period(period)
  );
endmodule

// File: rtl/hps_chk.sv
module hps_chk #(
  parameter int PW      = 11,
  parameter int ABS_MIN = 343,
  parameter int ABS_MAX = 1920,
  parameter int START_P = 800
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic          direct,
  input logic          started,
  input logic [PW-1:0] goal,
  input logic [PW-1:0] period,
  input logic          startup_done,
  input logic          drive_en,
  input logic          cfg_err
);
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(period) >= ABS_MIN) && (32'(period) <= ABS_MAX)); // R7

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !direct |=> (period == $past(period)) || (period == $past(period) + 1'b1)
                || (period == $past(period) - 1'b1)); // R3

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(period)); // R2

  AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
    !started |-> (period == PW'(START_P))); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    startup_done |=> startup_done && drive_en); // R5

  AST_DONE_AT_GOAL: assert property (@(posedge clk) disable iff (rst)
    $rose(startup_done) |-> $past(period) == $past(goal)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R8
endmodule

bind hperiod_slew hps_chk #(
  .PW(PW), .ABS_MIN(ABS_MIN), .ABS_MAX(ABS_MAX), .START_P(START_P)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .direct(direct), .started(started),
  .goal(goal), .period(period), .startup_done(startup_done),
  .drive_en(drive_en), .cfg_err(cfg_err)
);

// File: tb/hperiod_slew_tb.sv
module hperiod_slew_tb;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {16'd1000, 16'd1000},
    {16'd2000, 16'd1500},
    {16'd100,  16'd500},
    {16'd1500, 16'd1500},
    {16'd499,  16'd500},
    {16'd1200, 16'd1200}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [10:0] period;
  logic        startup_done, drive_en, cfg_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hperiod_slew u_dut (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .startup_done(startup_done),
    .drive_en(drive_en), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Walk until period reaches exp and stays; count unit-step and spacing errors.
  task automatic settle(input string req, input int exp, input int gap);
    int prev, last_t, bad_d, bad_iv, hold;
    prev = period; last_t = -1; bad_d = 0; bad_iv = 0; hold = 0;
    for (int t = 0; t < 20000 && hold < 2 * gap + 6; t++) begin
      @(negedge clk);
      if (int'(period) != prev) begin
        if (int'(period) - prev != 1 && prev - int'(period) != 1) bad_d++;
        if (last_t >= 0 && t - last_t != gap + 1) bad_iv++;
        last_t = t;
        prev = period;
      end
      hold = (int'(period) == exp) ? hold + 1 : 0;
    end
    chk({req, " final period"}, period, exp);
    chk("R3 unit steps", bad_d, 0);
    chk("R3 step spacing", bad_iv, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int p, prev, last_t, bad_iv;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 period", period, 800);
    chk("R1 startup_done", startup_done, 0);
    chk("R1 drive_en", drive_en, 0);
    chk("R1 cfg_err", cfg_err, 0);

    wr(2, 500); wr(3, 1500); wr(4, 2); wr(1, 820);
    idle(20);
    chk("R2 held before ce", period, 800);

    // R4: start-up, rewrite during it must be ignored
    ce = 1'b1;
    idle(5);
    wr(1, 1400);
    prev = period; last_t = -1; bad_iv = 0;
    for (int t = 0; t < 2000 && !startup_done; t++) begin
      @(negedge clk);
      if (int'(period) != prev) begin
        if (last_t >= 0 && t - last_t != 3) bad_iv++;
        last_t = t; prev = period;
      end
    end
    chk("R4 startup goal frozen", period, 820);
    chk("R5 startup_done high", startup_done, 1);
    chk("R5 drive_en with done", drive_en, 1);
    chk("R3 startup spacing", bad_iv, 0);

    // R6 new goal accepted after start-up
    settle("R6", 1400, 2);

    // R8 write-once
    wr(4, 0);
    chk("R8 err set", cfg_err, 1);
    wr(2, 300);
    wr(3, 1900);

    // R7 vector table (limits 500..1500, gap still 2)
    for (int i = 0; i < NV; i++) begin
      wr(1, int'(VEC[i][31:16]));
      settle("R7 table", int'(VEC[i][15:0]), 2);
    end

    // R2 ce pause in mid walk
    wr(1, 1230);
    idle(12);
    ce = 1'b0;
    p = period;
    idle(30);
    chk("R2 frozen while ce low", period, p);
    checks++;
    if (p == 1200 || p == 1230) begin
      fails++;
      $display("FAIL R2 pause mid-walk: got %0d expected %0d", p, 1215);
    end
    ce = 1'b1;
    settle("R2 resume", 1230, 2);

    // R10 unmapped address
    wr(5, 0);
    wr(7, 343);
    idle(10);
    chk("R10 unmapped period", period, 1230);
    chk("R10 unmapped err", cfg_err, 1);

    // R9 direct load
    wr(0, 1);
    wr(1, 700);
    idle(2);
    chk("R9 direct load", period, 700);

    // Second reset: saturation of written values
    rst = 1'b1; ce = 1'b0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 period after reset", period, 800);
    chk("R1 err after reset", cfg_err, 0);
    wr(3, 3000); wr(2, 10); wr(0, 1); wr(1, 2047);
    ce = 1'b1;
    for (int t = 0; t < 100 && !startup_done; t++) @(negedge clk);
    chk("R7 saturated upper", period, 1920);
    wr(1, 0);
    idle(2);
    chk("R7 saturated lower", period, 343);
    chk("R8 first writes no err", cfg_err, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule